// File: doc/BRIEF.md
# Audio Clock Ratio and Rate Detector

This block watches a serial audio bit clock and its frame sync, both sampled by a faster reference clock. For every frame it counts bit-clock rising edges and reference cycles. The edge count becomes a 4-bit ratio code, and the frame length becomes a 3-bit rate-family code. A measurement is published only after it has stayed the same for several consecutive frames. From the published codes the block also derives how many 32-bit slots fit in a frame.

The block raises a clock fault in three cases: the ratio is not supported, the frame sync stops arriving, or, in automatic mode, the measured rate family differs from the configured one. While the fault is present, the playback gain steps down by one count per frame toward zero. Once the clocks have been valid for enough frames, the fault clears and the gain steps back up to the configured level. A done flag marks each end of the ramp.

Top module: `audclk_guard`

## Requirements
- R1: The number of bit-clock rising edges in a frame maps to a ratio code: 64 gives 4'h4, 96 gives 4'h5, 128 gives 4'h6, 192 gives 4'h7, 256 gives 4'h8, 384 gives 4'h9 and 512 gives 4'h A. Codes 4'h0 to 4'h3 and 4'hB to 4'hE never appear.
- R2: Any other edge count gives ratio code 4'hF, and a frame with that count raises the fault.
- R3: The frame length L in reference cycles is classified against nominal lengths. With P = FRAME_REF_48K, the nominal lengths are 3P (code 3'b001), 3P/2 (3'b011), P (3'b100), P/2 (3'b101) and P/4 (3'b110). A frame lies in a family when nom-nom/20 <= L <= nom+nom/7, so the 44.1 kHz and 48 kHz variants share one code. A length outside every window gives 3'b000.
- R4: With auto_off low, a frame whose rate code is 3'b000 or differs from cfg_rate is a faulty frame. With auto_off high, the rate code plays no part in the fault.
- R5: A frame starts at each rising edge of the frame sync, and the first edge after reset or after a timeout only arms the measurement. The codes are published when the same (ratio, rate) pair has been measured STABLE_FRAMES times in a row (default 4). A single faulty frame sets the fault at once. The fault clears only when a good pair reaches the stability count.
- R6: At each measured frame end, the gain moves one step toward its target: 0 while the fault is set, cfg_gain otherwise. ramp_done is high exactly when the gain equals that target.
- R7: If TIMEOUT_CYC reference cycles pass with no frame-sync rising edge, the ratio code becomes 4'hF, the rate code becomes 3'b000 and the fault is set. The gain steps down once per timeout period, and the next edge only re-arms the measurement.
- R8: slot_count is the published edge count divided by 32 (0 for code 4'hF). It is capped at 4 for rate code 3'b110, at 8 for 3'b101 and at 16 otherwise.
- R9: After reset the ratio code is 4'hF, the rate code 3'b000, the fault is set, the gain is 0, ramp_done is high and slot_count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Bit clock, sampled by clk |
| fsync | input | 1 | Frame sync, rising edge starts a frame |
| auto_off | input | 1 | High disables the rate comparison |
| cfg_rate | input | 3 | Configured rate-family code |
| cfg_gain | input | GAIN_W | Configured playback gain |
| ratio_code | output | 4 | Published bit-clocks-per-frame code |
| rate_code | output | 3 | Published rate-family code |
| slot_count | output | 5 | Number of 32-bit slots per frame |
| clk_fault | output | 1 | Clock fault flag |
| play_gain | output | GAIN_W | Ramped playback gain |
| ramp_done | output | 1 | Gain has reached its current target |

## Verification
The frame streams cover every rate family with several ratios, including 512 bit clocks at one reference cycle per half period. This shows that each edge is counted and that the ratio and rate decoders work independently of each other. A 44.1 kHz frame at the edge of the 48k window checks that the two variants merge. A 100-edge frame and an out-of-window frame length each produce a fault. The same 96k stream is run with automatic mode on and then off, which separates a rate mismatch from a ratio error. A long silence on the frame sync exercises the timeout, the re-arm and the ramp recovery that follows.

// File: rtl/audclk_pkg.sv
package audclk_pkg;
    typedef logic [3:0] ratio_t;
    typedef logic [2:0] rate_t;

    localparam ratio_t RATIO_ERR = 4'hF;
    localparam rate_t  RATE_NONE = 3'b000;
    localparam int     NFAM      = 5;

    // Bit-clock count per frame to ratio code
    function automatic ratio_t ratio_of_count(input int n);
        case (n)
            64:      return 4'h4;
            96:      return 4'h5;
            128:     return 4'h6;
            192:     return 4'h7;
            256:     return 4'h8;
            384:     return 4'h9;
            512:     return 4'hA;
            default: return RATIO_ERR;
        endcase
    endfunction

    // Family index to rate code, slowest family first
    function automatic rate_t fam_code(input int i);
        case (i)
            0:       return 3'b001;
            1:       return 3'b011;
            2:       return 3'b100;
            3:       return 3'b101;
            default: return 3'b110;
        endcase
    endfunction

    // Slots of 32 bits, limited by the rate family
    function automatic logic [4:0] slots_of(input ratio_t r, input rate_t f);
        logic [4:0] base;
        logic [4:0] cap;
        case (r)
            4'h4:    base = 5'd2;
            4'h5:    base = 5'd3;
            4'h6:    base = 5'd4;
            4'h7:    base = 5'd6;
            4'h8:    base = 5'd8;
            4'h9:    base = 5'd12;
            4'hA:    base = 5'd16;
            default: base = 5'd0;
        endcase
        case (f)
            3'b110:  cap = 5'd4;
            3'b101:  cap = 5'd8;
            default: cap = 5'd16;
        endcase
        return (base < cap) ? base : cap;
    endfunction
endpackage

// File: rtl/audclk_edge.sv
module audclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic fsync,
    output logic bclk_rise,
    output logic frame_tick
);
    typedef struct packed {
        logic bclk;
        logic fsync;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d.bclk  = bclk;
        st_d.fsync = fsync;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bclk_rise  = bclk  & ~st_q.bclk;
    assign frame_tick = fsync & ~st_q.fsync;
endmodule

// File: rtl/audclk_meas.sv
module audclk_meas #(
    parameter int CNT_W       = 10,
    parameter int TIMEOUT_CYC = 4096,
    localparam int PER_W      = $clog2(TIMEOUT_CYC + 1) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_rise,
    input  logic             frame_tick,
    output logic             meas_valid,
    output logic             timeout,
    output logic [CNT_W-1:0] meas_cnt,
    output logic [PER_W-1:0] meas_per
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PER_W-1:0] per;
        logic             armed;
    } meas_st_t;

    meas_st_t st_d, st_q;

    assign timeout    = !frame_tick && (st_q.per == PER_W'(TIMEOUT_CYC));
    assign meas_valid = frame_tick && st_q.armed;
    assign meas_cnt   = st_q.cnt;
    assign meas_per   = st_q.per;

    always_comb begin
        st_d = st_q;
        if (frame_tick) begin
            st_d.cnt   = bclk_rise ? CNT_W'(1) : '0;
            st_d.per   = PER_W'(1);
            st_d.armed = 1'b1;
        end else if (timeout) begin
            st_d.cnt   = '0;
            st_d.per   = PER_W'(1);
            st_d.armed = 1'b0;
        end else begin
            st_d.per = st_q.per + PER_W'(1);
            if (bclk_rise && (st_q.cnt != '1))
                st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/audclk_rate.sv
module audclk_rate
    import audclk_pkg::*;
#(
    parameter int PER_W         = 14,
    parameter int FRAME_REF_48K = 1024
) (
    input  logic [PER_W-1:0] per,
    output rate_t            rate
);
    function automatic int fam_nom(input int i);
        case (i)
            0:       return 3 * FRAME_REF_48K;
            1:       return (3 * FRAME_REF_48K) / 2;
            2:       return FRAME_REF_48K;
            3:       return FRAME_REF_48K / 2;
            default: return FRAME_REF_48K / 4;
        endcase
    endfunction

    logic [NFAM-1:0] hit;

    for (genvar i = 0; i < NFAM; i++) begin : g_fam
        localparam int NOM = fam_nom(i);
        localparam int LO  = NOM - NOM / 20;
        localparam int HI  = NOM + NOM / 7;
        assign hit[i] = (int'(per) >= LO) && (int'(per) <= HI);
    end

    always_comb begin
        rate = RATE_NONE;
        for (int i = 0; i < NFAM; i++)
            if (hit[i]) rate = fam_code(i);
    end
endmodule

// File: rtl/audclk_track.sv
module audclk_track
    import audclk_pkg::*;
#(
    parameter int GAIN_W        = 8,
    parameter int STABLE_FRAMES = 4,
    localparam int SW           = $clog2(STABLE_FRAMES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              meas_valid,
    input  logic              timeout,
    input  ratio_t            meas_ratio,
    input  rate_t             meas_rate,
    input  logic              auto_off,
    input  rate_t             cfg_rate,
    input  logic [GAIN_W-1:0] cfg_gain,
    output ratio_t            ratio_code,
    output rate_t             rate_code,
    output logic              fault,
    output logic [GAIN_W-1:0] gain,
    output logic              ramp_done
);
    localparam logic [SW-1:0] STAB_MAX = SW'(STABLE_FRAMES);

    typedef struct packed {
        ratio_t            cand_ratio;
        rate_t             cand_rate;
        logic [SW-1:0]     stab;
        ratio_t            ratio;
        rate_t             rate;
        logic              fault;
        logic [GAIN_W-1:0] gain;
        logic              done;
    } trk_st_t;

    trk_st_t st_d, st_q;

    always_comb begin
        logic              step;
        logic              good;
        logic [GAIN_W-1:0] tgt;
        st_d = st_q;
        step = 1'b0;
        good = (meas_ratio != RATIO_ERR) &&
               (auto_off || ((meas_rate != RATE_NONE) && (meas_rate == cfg_rate)));
        if (timeout) begin
            st_d.ratio = RATIO_ERR;
            st_d.rate  = RATE_NONE;
            st_d.fault = 1'b1;
            st_d.stab  = '0;
            step       = 1'b1;
        end else if (meas_valid) begin
            if ((meas_ratio == st_q.cand_ratio) && (meas_rate == st_q.cand_rate)) begin
                if (st_q.stab < STAB_MAX) st_d.stab = st_q.stab + SW'(1);
            end else begin
                st_d.cand_ratio = meas_ratio;
                st_d.cand_rate  = meas_rate;
                st_d.stab       = SW'(1);
            end
            if (st_d.stab == STAB_MAX) begin
                st_d.ratio = meas_ratio;
                st_d.rate  = meas_rate;
            end
            if (!good)                       st_d.fault = 1'b1;
            else if (st_d.stab == STAB_MAX)  st_d.fault = 1'b0;
            step = 1'b1;
        end
        tgt = st_d.fault ? '0 : cfg_gain;
        if (step) begin
            if (st_q.gain < tgt)      st_d.gain = st_q.gain + GAIN_W'(1);
            else if (st_q.gain > tgt) st_d.gain = st_q.gain - GAIN_W'(1);
        end
        st_d.done = (st_d.gain == tgt);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.cand_ratio <= RATIO_ERR;
            st_q.ratio      <= RATIO_ERR;
            st_q.rate       <= RATE_NONE;
            st_q.fault      <= 1'b1;
            st_q.done       <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ratio_code = st_q.ratio;
    assign rate_code  = st_q.rate;
    assign fault      = st_q.fault;
    assign gain       = st_q.gain;
    assign ramp_done  = st_q.done;
endmodule

// File: rtl/audclk_guard.sv
module audclk_guard
    import audclk_pkg::*;
#(
    parameter int GAIN_W        = 8,
    parameter int CNT_W         = 10,
    parameter int FRAME_REF_48K = 1024,
    parameter int TIMEOUT_CYC   = 4096,
    parameter int STABLE_FRAMES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk,
    input  logic              fsync,
    input  logic              auto_off,
    input  logic [2:0]        cfg_rate,
    input  logic [GAIN_W-1:0] cfg_gain,
    output logic [3:0]        ratio_code,
    output logic [2:0]        rate_code,
    output logic [4:0]        slot_count,
    output logic              clk_fault,
    output logic [GAIN_W-1:0] play_gain,
    output logic              ramp_done
);
    localparam int PER_W = $clog2(TIMEOUT_CYC + 1) + 1;

    logic             bclk_rise, frame_tick, meas_valid, timeout;
    logic [CNT_W-1:0] meas_cnt;
    logic [PER_W-1:0] meas_per;
    ratio_t           meas_ratio;
    rate_t            meas_rate;

    audclk_edge u_edge (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
        .bclk_rise(bclk_rise), .frame_tick(frame_tick)
    );

    audclk_meas #(.CNT_W(CNT_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_meas (
        .clk(clk), .rst_n(rst_n), .bclk_rise(bclk_rise), .frame_tick(frame_tick),
        .meas_valid(meas_valid), .timeout(timeout),
        .meas_cnt(meas_cnt), .meas_per(meas_per)
    );

    assign meas_ratio = ratio_of_count(int'(meas_cnt));

    audclk_rate #(.PER_W(PER_W), .FRAME_REF_48K(FRAME_REF_48K)) u_rate (
        .per(meas_per), .rate(meas_rate)
    );

    audclk_track #(.GAIN_W(GAIN_W), .STABLE_FRAMES(STABLE_FRAMES)) u_track (
        .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .timeout(timeout),
        .meas_ratio(meas_ratio), .meas_rate(meas_rate), .auto_off(auto_off),
        .cfg_rate(cfg_rate), .cfg_gain(cfg_gain),
        .ratio_code(ratio_code), .rate_code(rate_code), .fault(clk_fault),
        .gain(play_gain), .ramp_done(ramp_done)
    );

    assign slot_count = slots_of(ratio_code, rate_code);
endmodule

// File: rtl/audclk_guard_chk.sv
module audclk_guard_chk #(
    parameter int GAIN_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        ratio_code,
    input logic [2:0]        rate_code,
    input logic [4:0]        slot_count,
    input logic              clk_fault,
    input logic [GAIN_W-1:0] play_gain,
    input logic              ramp_done
);
    // R1
    ratio_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_code >= 4'h4 && ratio_code <= 4'hA) || ratio_code == 4'hF);

    // R3
    rate_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_code != 3'b010 && rate_code != 3'b111);

    // R2
    err_ratio_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_code == 4'hF |-> clk_fault);

    // R6
    gain_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (play_gain == $past(play_gain)) || (play_gain == $past(play_gain) + GAIN_W'(1)) ||
        (play_gain + GAIN_W'(1) == $past(play_gain)));

    // R6
    no_rise_in_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_fault |-> play_gain <= $past(play_gain));

    // R6
    fault_done_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_fault && ramp_done) |-> play_gain == '0);

    // R8
    slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_count <= 5'd16);
endmodule

bind audclk_guard audclk_guard_chk #(.GAIN_W(GAIN_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .ratio_code(ratio_code), .rate_code(rate_code),
    .slot_count(slot_count), .clk_fault(clk_fault), .play_gain(play_gain),
    .ramp_done(ramp_done)
);

// File: tb/audclk_guard_tb_top.sv
module audclk_guard_tb_top;
    localparam int P     = 1024;
    localparam int TMO   = 4096;
    localparam int STAB  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bclk = 1'b0;
    logic       fsync = 1'b0;
    logic       auto_off = 1'b0;
    logic [2:0] cfg_rate = 3'b100;
    logic [7:0] cfg_gain = 8'd3;
    logic [3:0] ratio_code;
    logic [2:0] rate_code;
    logic [4:0] slot_count;
    logic       clk_fault;
    logic [7:0] play_gain;
    logic       ramp_done;

    always #2 clk = ~clk;

    audclk_guard dut_i (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .auto_off(auto_off),
        .cfg_rate(cfg_rate), .cfg_gain(cfg_gain), .ratio_code(ratio_code),
        .rate_code(rate_code), .slot_count(slot_count), .clk_fault(clk_fault),
        .play_gain(play_gain), .ramp_done(ramp_done)
    );

    typedef struct {
        int    due;
        int    ratio;
        int    rate;
        int    fault;
        int    gain;
        int    done;
        int    slots;
        string req;
    } exp_t;

    exp_t q[$];
    int   errors = 0;
    int   checks = 0;
    int   cyc    = 0;
    bit   fin    = 0;

    // bench model state
    int m_armed = 0, m_stab = 0, m_cr = 15, m_cf = 0;
    int m_ratio = 15, m_rate = 0, m_fault = 1, m_gain = 0, m_rn = 0, m_cn = 0;
    int prev_r = 0, prev_len = 0;

    function automatic int e_ratio(int r);
        case (r)
            64: return 4; 96: return 5; 128: return 6; 192: return 7;
            256: return 8; 384: return 9; 512: return 10;
            default: return 15;
        endcase
    endfunction

    function automatic int in_win(int len, int nom);
        return (len >= nom - nom / 20 && len <= nom + nom / 7) ? 1 : 0;
    endfunction

    function automatic int e_rate(int len);
        if (in_win(len, 3 * P) != 0)     return 1;
        if (in_win(len, 3 * P / 2) != 0) return 3;
        if (in_win(len, P) != 0)         return 4;
        if (in_win(len, P / 2) != 0)     return 5;
        if (in_win(len, P / 4) != 0)     return 6;
        return 0;
    endfunction

    function automatic int e_slots(int rn, int rate);
        int cap;
        cap = (rate == 6) ? 4 : (rate == 5) ? 8 : 16;
        return (rn / 32 < cap) ? rn / 32 : cap;
    endfunction

    task automatic push(string req);
        exp_t e;
        int   tgt;
        tgt     = (m_fault != 0) ? 0 : int'(cfg_gain);
        e.due   = cyc + 2;
        e.ratio = m_ratio;
        e.rate  = m_rate;
        e.fault = m_fault;
        e.gain  = m_gain;
        e.done  = (m_gain == tgt) ? 1 : 0;
        e.slots = (m_ratio == 15) ? 0 : e_slots(m_rn, m_rate);
        e.req   = req;
        q.push_back(e);
    endtask

    // model update at a frame-sync rising edge, from the frame that just ended
    task automatic model_tick(string req);
        int mr, mf, good, tgt;
        if (m_armed == 0) begin
            m_armed = 1;
        end else begin
            mr = e_ratio(prev_r);
            mf = e_rate(prev_len);
            if (mr == m_cr && mf == m_cf) begin
                if (m_stab < STAB) m_stab++;
            end else begin
                m_cr = mr; m_cf = mf; m_cn = (mr == 15) ? 0 : prev_r; m_stab = 1;
            end
            if (m_stab == STAB) begin
                m_ratio = mr; m_rate = mf; m_rn = m_cn;
            end
            good = (mr != 15) && ((auto_off == 1'b1) || (mf != 0 && mf == int'(cfg_rate)));
            if (good == 0)          m_fault = 1;
            else if (m_stab == STAB) m_fault = 0;
            tgt = (m_fault != 0) ? 0 : int'(cfg_gain);
            if (m_gain < tgt)      m_gain++;
            else if (m_gain > tgt) m_gain--;
        end
        push(req);
    endtask

    // n frames of r bit clocks, each bit clock 2h reference cycles
    task automatic frames(int r, int h, int n, string req);
        for (int k = 0; k < n; k++) begin
            model_tick(req);
            for (int c = 0; c < 2 * h * r; c++) begin
                bclk  = ((c % (2 * h)) < h);
                fsync = (c < h * r);
                @(negedge clk);
            end
            prev_r   = r;
            prev_len = 2 * h * r;
        end
    endtask

    // R7: frame sync stops; several timeout periods pass
    task automatic idle(int cycles);
        bclk  = 1'b0;
        fsync = 1'b0;
        repeat (cycles) @(negedge clk);
        m_armed = 0; m_stab = 0; m_ratio = 15; m_rate = 0; m_rn = 0;
        m_fault = 1; m_gain = 0;
        push("R7");
    endtask

    task automatic cmp(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: pop expected items once due and compare against the ports
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            while (q.size() > 0 && q[0].due <= cyc) begin
                exp_t e;
                e = q.pop_front();
                cmp(e.req, "ratio_code", int'(ratio_code), e.ratio);
                cmp(e.req, "rate_code",  int'(rate_code),  e.rate);
                cmp(e.req, "clk_fault",  int'(clk_fault),  e.fault);
                cmp(e.req, "play_gain",  int'(play_gain),  e.gain);
                cmp("R6",  "ramp_done",  int'(ramp_done),  e.done);
                cmp("R8",  "slot_count", int'(slot_count), e.slots);
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!fin) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        push("R9");
        repeat (3) @(negedge clk);
        frames(256, 2, 8, "R1");   // 48k family, ratio 256: settles, ramps up
        frames(100, 5, 2, "R2");   // unsupported count
        frames(64, 8, 7, "R5");    // recovery after stability run
        frames(64, 9, 6, "R3");    // 44.1k variant, same family code
        frames(128, 2, 6, "R4");   // 96k frames against 48k setting: mismatch
        auto_off = 1'b1;
        frames(128, 2, 6, "R4");   // same stream, rate comparison off
        frames(64, 2, 6, "R3");    // 192k family
        frames(64, 24, 5, "R3");   // 16k family
        frames(96, 8, 6, "R8");    // 32k family, 3 slots
        auto_off = 1'b0;
        frames(64, 7, 5, "R3");    // frame length in no window
        frames(512, 1, 6, "R1");   // 512 edges, 16 slots
        idle(5 * TMO);
        frames(256, 2, 9, "R7");   // re-arm and recover
        repeat (10) @(negedge clk);
        wait (q.size() == 0);
        fin = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule